// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block exchanges one byte at a time over a three-wire clocked serial link for a small microcontroller. Software programs a mode register (clock source, internal bit rate, pin ownership, bit order and receive source) and then writes a byte into the data register. That write loads the shift register and arms a transfer. Eight bits then leave on the data output pin while eight bits arrive from the chosen receive source. When the eighth bit has been taken in, a one-cycle interrupt request is raised. The received byte is then read back from the data register.

The serial clock comes from one of two sources. With the internal clock, the unit divides the system clock and drives eight clock pulses itself; the clock line idles high. With the external clock, the unit follows edges arriving on the clock input pin after synchronising them. In both cases the output bit changes on a falling clock edge and the input bit is sampled on a rising edge. The receive source can be switched to the data output pin, so that a single wire can carry traffic in both directions, one direction at a time.

Top module: `sio_unit`

## Requirements
- R1: After reset the mode register reads 0x00, the data register reads 0x00, `sck_out` is 1, both output enables are 0 and `irq` is 0.
- R2: The mode register (address 0) stores bits 6:0 as written and reads them back. Bit 7 always reads 0, whatever was written to it.
- R3: `sdo_oe` equals mode bit 3, and `sck_oe` equals mode bit 3 AND mode bit 2. Both follow one cycle after the mode write.
- R4: With mode bit 2 = 1, a data write (address 1) starts eight `sck_out` pulses. The period is 4, 16, 32 or 64 system clocks for mode bits 1:0 = 00, 01, 10, 11, with half of each period low. `sck_out` stays high when idle.
- R5: Mode bit 5 = 0 sends the written byte LSB first and bit 5 = 1 sends it MSB first. Each bit appears on `sdo_out` at the falling clock edge that opens its slot.
- R6: The receive bit is sampled at each rising clock edge and shifted in using the same bit order. After the transfer, a read of address 1 returns the received byte with the first bit at bit 0 (LSB first) or at bit 7 (MSB first).
- R7: `irq` is high for exactly one system clock after the eighth rising serial edge, once per transfer.
- R8: With mode bit 2 = 0, the unit shifts on synchronised edges of `sck_in` and stops after eight rising edges. Further edges change neither the data register nor `irq` until the next data write.
- R9: Mode bit 6 = 0 takes receive data from `sdi`. Mode bit 6 = 1 takes it from `sdo_pad_in`, the level seen on the data output pin.
- R10: A data write loads the byte at once. Before any serial edge, a read of address 1 returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mode, 1 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, valid one cycle after address |
| sck_in | input | 1 | Serial clock pin level (external clock) |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdi | input | 1 | Dedicated serial input pin |
| sdo_pad_in | input | 1 | Level seen on the data output pin |
| sdo_out | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for the data output pin |
| irq | output | 1 | Transfer-complete pulse |

## Verification
A wrong bit count shows up at the ports within one serial period: there is a ninth or seventh clock pulse, or `irq` arrives early or late relative to the eighth rising edge. A corrupted shift path or wrong order select shows in the bit seen at the very next falling edge, and in the byte read back after `irq`. A prescaler fault shows up as a wrong fall-to-fall spacing on the second pulse. A transfer that fails to stop shows up when later external edges alter the read-back byte or raise a second interrupt.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int SIO_DW = 8;

  typedef struct packed {
    logic       spare7;
    logic       rx_from_out;
    logic       msb_first;
    logic       rsvd4;
    logic       pins_on;
    logic       clk_internal;
    logic [1:0] rate;
  } sio_mode_t;

  // log2 of the half period in system clocks, per rate code
  function automatic logic [2:0] half_log2(input logic [1:0] rate);
    case (rate)
      2'd0:    half_log2 = 3'd1;
      2'd1:    half_log2 = 3'd3;
      2'd2:    half_log2 = 3'd4;
      default: half_log2 = 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '1;
    else     pipe[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '1;
        else     pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int MAX_HALF_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       rise_ev,
  output logic       fall_ev
);
  localparam int CW = MAX_HALF_LOG2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          tick;

  always_comb begin
    last = CW'((32'd1 << half_log2(rate)) - 32'd1);
    tick = run && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (run) begin
      if (tick) begin
        cnt <= '0;
        sck <= ~sck;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
      sck <= 1'b1;
    end
  end

  assign fall_ev = tick & sck;
  assign rise_ev = tick & ~sck;

  p_sck_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && !start) |=> $stable(sck));
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> sck);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] load,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         rx,
  input  logic         msb_first,
  output logic [W-1:0] data,
  output logic         sdo,
  output logic         busy,
  output logic         irq
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      sdo   <= 1'b1;
      busy  <= 1'b0;
      nbits <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        data  <= load;
        busy  <= 1'b1;
        nbits <= '0;
      end else if (busy) begin
        if (fall_ev)
          sdo <= msb_first ? data[W-1] : data[0];
        if (rise_ev) begin
          data  <= msb_first ? {data[W-2:0], rx} : {rx, data[W-1:1]};
          nbits <= nbits + 1'b1;
          if (nbits == CW'(W-1)) begin
            busy <= 1'b0;
            irq  <= 1'b1;
          end
        end
      end
    end
  end

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  p_irq_end_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && $past(busy)));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(data));
endmodule

// File: rtl/sio_unit.sv
module sio_unit
  import sio_pkg::*;
#(
  parameter int DW            = SIO_DW,
  parameter int SYNC_STAGES   = 2,
  parameter int MAX_HALF_LOG2 = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          sdi,
  input  logic          sdo_pad_in,
  output logic          sdo_out,
  output logic          sdo_oe,
  output logic          irq
);
  sio_mode_t     mode_q;
  logic          start;
  logic [2:0]    pin_s;
  logic          sck_prev;
  logic          ext_rise, ext_fall;
  logic          int_rise, int_fall;
  logic          rise_ev, fall_ev, rx_bit;
  logic          busy;
  logic [DW-1:0] shreg;

  assign start = reg_wr && reg_addr;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (reg_wr && !reg_addr) begin
      mode_q        <= sio_mode_t'(reg_wdata[7:0]);
      mode_q.spare7 <= 1'b0;
    end
  end

  sio_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sck_in, sdi, sdo_pad_in}),
    .q   (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b1;
    else     sck_prev <= pin_s[2];
  end

  assign ext_rise = !sck_prev &&  pin_s[2];
  assign ext_fall =  sck_prev && !pin_s[2];

  sio_clkgen #(.MAX_HALF_LOG2(MAX_HALF_LOG2)) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .run     (busy && mode_q.clk_internal),
    .rate    (mode_q.rate),
    .sck     (sck_out),
    .rise_ev (int_rise),
    .fall_ev (int_fall)
  );

  always_comb begin
    if (mode_q.clk_internal) begin
      rise_ev = int_rise;
      fall_ev = int_fall;
      rx_bit  = mode_q.rx_from_out ? sdo_pad_in : sdi;
    end else begin
      rise_ev = ext_rise;
      fall_ev = ext_fall;
      rx_bit  = mode_q.rx_from_out ? pin_s[0] : pin_s[1];
    end
  end

  sio_shifter #(.W(DW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .load      (reg_wdata),
    .fall_ev   (fall_ev),
    .rise_ev   (rise_ev),
    .rx        (rx_bit),
    .msb_first (mode_q.msb_first),
    .data      (shreg),
    .sdo       (sdo_out),
    .busy      (busy),
    .irq       (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_oe    <= 1'b0;
      sdo_oe    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      sck_oe    <= mode_q.pins_on && mode_q.clk_internal;
      sdo_oe    <= mode_q.pins_on;
      reg_rdata <= reg_addr ? shreg : DW'(mode_q);
    end
  end

  p_oe_off_r3: assert property (@(posedge clk) disable iff (rst)
    !mode_q.pins_on |=> (!sck_oe && !sdo_oe));
  p_mode_b7_r2: assert property (@(posedge clk) disable iff (rst)
    !reg_addr |=> !reg_rdata[7]);
endmodule

// File: tb/sio_unit_test.sv
module sio_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe;
  logic       sdi = 1'b1;
  logic       sdo_pad_in;
  logic       sdo_out, sdo_oe;
  logic       irq;
  logic       loop_en = 1'b0;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdo_pad_in = loop_en ? sdo_out : 1'b1;

  always @(posedge clk) if (irq) irq_seen <= irq_seen + 1;

  sio_unit uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo_pad_in(sdo_pad_in),
    .sdo_out(sdo_out), .sdo_oe(sdo_oe), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_int(input int rate, input bit msb, input bit loop,
                         input logic [7:0] tx, input logic [7:0] rx);
    int per, base, falls, rises, cyc, lastf;
    bit prev;
    logic [7:0] got, rd, exp_rx;
    per = (rate == 0) ? 4 : (8 << rate);
    loop_en = loop;
    write_reg(1'b0, {1'b0, loop, msb, 1'b0, 1'b1, 1'b1, 2'(rate)});
    base = irq_seen; falls = 0; rises = 0; lastf = 0; got = '0;
    write_reg(1'b1, tx);
    prev = sck_out; cyc = 0;
    while (cyc < 8 * per + 40 && irq_seen == base) begin
      @(negedge clk);
      cyc++;
      if (prev && !sck_out) begin
        if (falls < 8) begin
          if (msb) got[7-falls] = sdo_out; else got[falls] = sdo_out;
          sdi = msb ? rx[7-falls] : rx[falls];
        end
        if (falls > 0) chk(cyc - lastf == per, "R4 period", cyc - lastf, per);
        lastf = cyc;
        falls++;
      end
      if (!prev && sck_out) rises++;
      prev = sck_out;
    end
    chk(falls == 8, "R4 pulse count", falls, 8);
    chk(rises == 8, "R4 rising count", rises, 8);
    chk(sck_out == 1'b1, "R4 idle high", sck_out, 1);
    chk(got == tx, "R5 transmitted byte", got, tx);
    repeat (per) @(negedge clk);
    chk(irq_seen - base == 1, "R7 one irq", irq_seen - base, 1);
    read_reg(1'b1, rd);
    exp_rx = loop ? tx : rx;
    chk(rd == exp_rx, loop ? "R9 loopback byte" : "R6 received byte", rd, exp_rx);
    loop_en = 1'b0;
  endtask

  task automatic sck_pulse(input bit capture, input bit msb, input int k,
                           input logic [7:0] rx, inout logic [7:0] got);
    @(negedge clk);
    sck_in = 1'b0;
    repeat (4) @(negedge clk);
    if (capture) begin
      if (msb) got[7-k] = sdo_out; else got[k] = sdo_out;
      sdi = msb ? rx[7-k] : rx[k];
    end
    repeat (4) @(negedge clk);
    sck_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_ext(input bit msb, input bit loop,
                         input logic [7:0] tx, input logic [7:0] rx);
    int base;
    logic [7:0] got, rd, rd2, exp_rx;
    loop_en = loop;
    write_reg(1'b0, {1'b0, loop, msb, 1'b0, 1'b1, 1'b0, 2'b11});
    base = irq_seen; got = '0;
    write_reg(1'b1, tx);
    read_reg(1'b1, rd);
    chk(rd == tx, "R10 loaded byte", rd, tx);
    chk(sck_oe == 1'b0 && sdo_oe == 1'b1, "R3 external pins", {sck_oe, sdo_oe}, 1);
    for (int k = 0; k < 8; k++) sck_pulse(1'b1, msb, k, rx, got);
    repeat (4) @(negedge clk);
    chk(got == tx, "R5 external transmit", got, tx);
    chk(irq_seen - base == 1, "R7 external irq", irq_seen - base, 1);
    read_reg(1'b1, rd);
    exp_rx = loop ? tx : rx;
    chk(rd == exp_rx, loop ? "R9 external loopback" : "R8 external receive", rd, exp_rx);
    sdi = ~sdi;
    for (int k = 0; k < 3; k++) sck_pulse(1'b0, msb, k, rx, got);
    read_reg(1'b1, rd2);
    chk(rd2 == rd, "R8 extra edges ignored", rd2, rd);
    chk(irq_seen - base == 1, "R8 no extra irq", irq_seen - base, 1);
    loop_en = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] txs [3];
    txs[0] = 8'hA5; txs[1] = 8'h3C; txs[2] = 8'h81;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sck_out == 1'b1, "R1 sck idle", sck_out, 1);
    chk(sck_oe == 1'b0 && sdo_oe == 1'b0, "R1 enables", {sck_oe, sdo_oe}, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    read_reg(1'b0, rd);
    chk(rd == 8'h00, "R1 mode reset", rd, 0);
    read_reg(1'b1, rd);
    chk(rd == 8'h00, "R1 data reset", rd, 0);

    for (int v = 0; v < 256; v++) begin
      write_reg(1'b0, 8'(v));
      read_reg(1'b0, rd);
      chk(rd == 8'(v & 8'h7F), "R2 mode readback", rd, v & 8'h7F);
      chk(sdo_oe == v[3], "R3 sdo_oe", sdo_oe, v[3]);
      chk(sck_oe == (v[3] & v[2]), "R3 sck_oe", sck_oe, v[3] & v[2]);
    end
    chk(irq_seen == 0, "R7 no irq from mode writes", irq_seen, 0);

    for (int r = 0; r < 4; r++)
      for (int o = 0; o < 2; o++)
        for (int p = 0; p < 3; p++)
          run_int(r, o[0], 1'b0, txs[p], {txs[p][3:0], txs[p][7:4]} ^ 8'h0F ^ 8'(r));

    run_int(0, 1'b0, 1'b1, 8'h6B, 8'h00);
    run_int(1, 1'b1, 1'b1, 8'hD2, 8'hFF);

    run_ext(1'b0, 1'b0, 8'hC3, 8'h5E);
    run_ext(1'b1, 1'b0, 8'h17, 8'hB4);
    run_ext(1'b1, 1'b1, 8'h9A, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule